// File: doc/BRIEF.md
# Ethernet Receive Frame Checker with Status and Interrupt

This block sits behind a receive address filter. It takes each frame that the filter has already accepted as a byte stream, one byte per valid cycle, with a marker on the final byte. While the bytes stream in, it counts the frame length and runs a CRC-32 over every byte, including the trailing frame check sequence. On the final byte it classifies the frame as good, CRC error or short. It places the frame bytes in a host-side FIFO. The four check bytes are dropped unless a command bit asks to keep them.

Each FIFO entry carries an end-of-frame flag. A frame becomes visible to the host only once it is complete. A receive status byte and a transmit status byte each carry an "old" flag in bit 7. Reading a status byte sets its old flag. A completed frame is thrown away if the previous receive status has not been read. One interrupt line combines unread receive and transmit events, each gated by mask bits in its own command register. The transmit status is loaded from an event port driven by the transmit path.

Top module: `rx_frame_check`

## Requirements
- R1: After reset, both status outputs read 0x80 (old flag set, no event bits), the command registers are cleared, the FIFO is empty, `rx_ready` is low and `irq` is low.
- R2: A frame of fewer than MIN_LEN (64) bytes, check bytes included, sets the receive status to 0x04 (bit 2, short).
- R3: A frame of at least MIN_LEN bytes is checked by running a reflected CRC-32 (all-ones start) over every byte. If the register does not end at 0xDEBB20E3, the status becomes 0x02 (bit 1, CRC error); if it does, the status becomes 0x01 (bit 0, good).
- R4: Receive command bit 3 clear strips the last four bytes of each stored frame. With bit 3 set, every byte is stored.
- R5: `rx_ready` rises in the cycle after the final byte of a stored frame is taken in, and falls after the last stored byte is read. `fifo_eof` is high only while that last byte is presented. A read request while `rx_ready` is low has no effect.
- R6: A frame that starts while the receive status old flag (bit 7) is clear is dropped. Neither the status nor the FIFO changes.
- R7: A status read request sets bit 7 of that status in the next cycle, and the interrupt that status raised is removed. A frame completing in the same cycle takes precedence over a receive read.
- R8: `irq` is high exactly when a status has its old flag clear and its event bits ANDed with the matching command mask are nonzero. The receive mask is command bits 2:0 and the transmit mask is command bits 3:0.
- R9: A `tx_evt_valid` pulse loads the transmit status with the event code in bits 3:0 and a clear old flag.
- R10: A frame whose stored bytes would exceed the FIFO space is discarded as a whole. The status is left unchanged, and frames already stored, as well as later frames, are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming frame byte valid |
| in_data | input | 8 | Incoming frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| cmd_rx_we | input | 1 | Write the receive command register |
| cmd_tx_we | input | 1 | Write the transmit command register |
| cmd_wdata | input | 4 | Command write data |
| rx_stat_rd | input | 1 | Receive status read request (sets old flag) |
| rx_stat | output | 8 | Receive status |
| tx_stat_rd | input | 1 | Transmit status read request (sets old flag) |
| tx_stat | output | 8 | Transmit status |
| tx_evt_valid | input | 1 | Transmit event strobe |
| tx_evt_code | input | 4 | Transmit event bits |
| fifo_rd | input | 1 | Pop one byte from the host FIFO |
| fifo_data | output | 8 | Byte at the FIFO head |
| fifo_eof | output | 1 | The head byte is the last byte of its frame |
| rx_ready | output | 1 | Stored frame data is pending |
| irq | output | 1 | Interrupt request |

## Verification
Status, `rx_ready` and the first stored byte are all due one cycle after the edge that takes in the final frame byte. The bench drives each byte at a falling edge and samples these results at the next falling edge after the last byte. A read request or command write shows its effect on status and `irq` one edge later, and the bench samples at the falling edge that follows. The FIFO monitor compares the head byte and its end flag at a falling edge, then pops with a request that the following rising edge consumes. Each compare therefore sees the entry that the previous pop exposed.

// File: rtl/rxchk_pkg.sv
package rxchk_pkg;
  localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY    = 32'hEDB8_8320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;

  // receive status event bit positions (bit 7 is the old flag)
  localparam int ST_GOOD  = 0;
  localparam int ST_CRC   = 1;
  localparam int ST_SHORT = 2;
  localparam int ST_OLD   = 7;
  // receive command: bits 2:0 mask, bit 3 keeps check bytes
  localparam int CMD_KEEP = 3;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/rxchk_classify.sv
module rxchk_classify
  import rxchk_pkg::*;
#(
  parameter int MIN_LEN = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_en,
  input  logic       byte_last,
  input  logic [7:0] byte_in,
  output logic       res_good,
  output logic       res_crc_bad,
  output logic       res_short
);
  localparam int CW = $clog2(MIN_LEN + 1);

  logic [31:0]   crc_q, crc_d, crc_nxt;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    crc_nxt     = crc_step(crc_q, byte_in);
    res_short   = (cnt_q < CW'(MIN_LEN - 1));
    res_crc_bad = !res_short && (crc_nxt != CRC_RESIDUE);
    res_good    = !res_short && (crc_nxt == CRC_RESIDUE);
    crc_d = crc_q;
    cnt_d = cnt_q;
    if (byte_en) begin
      if (byte_last) begin
        crc_d = CRC_INIT;
        cnt_d = '0;
      end else begin
        crc_d = crc_nxt;
        if (cnt_q != CW'(MIN_LEN)) cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_INIT;
      cnt_q <= '0;
    end else if (byte_en) begin
      crc_q <= crc_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rxchk_fcs_strip.sv
module rxchk_fcs_strip #(
  parameter int FCS_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       keep,
  input  logic       byte_en,
  input  logic       byte_last,
  input  logic [7:0] byte_in,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last
);
  localparam int FW = $clog2(FCS_BYTES + 1);

  logic [7:0]    dl_q [FCS_BYTES];
  logic [7:0]    dl_d [FCS_BYTES];
  logic [FW-1:0] fill_q, fill_d;
  logic          primed;

  always_comb begin
    primed = (fill_q == FW'(FCS_BYTES));
    if (keep) begin
      out_valid = byte_en;
      out_data  = byte_in;
    end else begin
      out_valid = byte_en && primed;
      out_data  = dl_q[FCS_BYTES-1];
    end
    out_last = byte_last;

    dl_d[0] = byte_in;
    for (int i = 1; i < FCS_BYTES; i++) dl_d[i] = dl_q[i-1];

    fill_d = fill_q;
    if (byte_en) begin
      if (byte_last)   fill_d = '0;
      else if (!primed) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      for (int i = 0; i < FCS_BYTES; i++) dl_q[i] <= '0;
    end else if (byte_en) begin
      fill_q <= fill_d;
      for (int i = 0; i < FCS_BYTES; i++) dl_q[i] <= dl_d[i];
    end
  end
endmodule

// File: rtl/rxchk_fifo.sv
module rxchk_fifo #(
  parameter int DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wr_last,
  input  logic       frame_end,
  output logic       frame_fits,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_last,
  output logic       ready
);
  localparam int AW = $clog2(DEPTH);

  logic [8:0]  mem [DEPTH];
  logic [AW:0] wr_q, wr_d, cm_q, cm_d, rd_q, rd_d, count;
  logic        ovf_q, ovf_d, full, wr_fire, rd_fire, ovf_now;

  always_comb begin
    count      = wr_q - rd_q;
    full       = (count == (AW+1)'(DEPTH));
    ovf_now    = wr_en && full;
    wr_fire    = wr_en && !full && !ovf_q;
    ready      = (rd_q != cm_q);
    rd_fire    = rd_en && ready;
    frame_fits = !(ovf_q || ovf_now);
    {rd_last, rd_data} = mem[rd_q[AW-1:0]];

    rd_d  = rd_fire ? rd_q + 1'b1 : rd_q;
    wr_d  = wr_fire ? wr_q + 1'b1 : wr_q;
    cm_d  = cm_q;
    ovf_d = ovf_q || ovf_now;
    if (frame_end) begin
      ovf_d = 1'b0;
      if (frame_fits) cm_d = wr_d;
      else            wr_d = cm_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      cm_q  <= '0;
      rd_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      cm_q  <= cm_d;
      rd_q  <= rd_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_q[AW-1:0]] <= {wr_last, wr_data};
  end

  // R10
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));

  // R5
  no_read_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ready) |=> (rd_q == $past(rd_q)));
endmodule

// File: rtl/rxchk_status.sv
module rxchk_status
  import rxchk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_cmd_we,
  input  logic       tx_cmd_we,
  input  logic [3:0] cmd_wdata,
  input  logic       rx_rd,
  input  logic       tx_rd,
  input  logic       rx_upd,
  input  logic [2:0] rx_code,
  input  logic       tx_evt,
  input  logic [3:0] tx_code,
  output logic [7:0] rx_stat,
  output logic [7:0] tx_stat,
  output logic       keep_fcs,
  output logic       rx_old,
  output logic       irq
);
  logic       rx_old_q, rx_old_d, tx_old_q, tx_old_d;
  logic [2:0] rx_ev_q, rx_ev_d;
  logic [3:0] tx_ev_q, tx_ev_d, rx_cmd_q, tx_cmd_q;

  always_comb begin
    rx_old_d = rx_old_q;
    rx_ev_d  = rx_ev_q;
    if (rx_upd) begin
      rx_old_d = 1'b0;
      rx_ev_d  = rx_code;
    end else if (rx_rd) begin
      rx_old_d = 1'b1;
    end
    tx_old_d = tx_old_q;
    tx_ev_d  = tx_ev_q;
    if (tx_evt) begin
      tx_old_d = 1'b0;
      tx_ev_d  = tx_code;
    end else if (tx_rd) begin
      tx_old_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_old_q <= 1'b1;
      tx_old_q <= 1'b1;
      rx_ev_q  <= '0;
      tx_ev_q  <= '0;
    end else begin
      rx_old_q <= rx_old_d;
      tx_old_q <= tx_old_d;
      rx_ev_q  <= rx_ev_d;
      tx_ev_q  <= tx_ev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_cmd_q <= '0;
    else if (rx_cmd_we) rx_cmd_q <= cmd_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx_cmd_q <= '0;
    else if (tx_cmd_we) tx_cmd_q <= cmd_wdata;
  end

  always_comb begin
    rx_stat  = {rx_old_q, 4'd0, rx_ev_q};
    tx_stat  = {tx_old_q, 3'd0, tx_ev_q};
    keep_fcs = rx_cmd_q[CMD_KEEP];
    rx_old   = rx_old_q;
    irq      = (!rx_old_q && |(rx_ev_q & rx_cmd_q[2:0])) ||
               (!tx_old_q && |(tx_ev_q & tx_cmd_q));
  end

  // R7
  rd_sets_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !rx_upd) |=> rx_stat[ST_OLD]);

  // R9
  tx_evt_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |=> (!tx_stat[7] && tx_stat[3:0] == $past(tx_code)));
endmodule

// File: rtl/rx_frame_check.sv
module rx_frame_check
  import rxchk_pkg::*;
#(
  parameter int MIN_LEN    = 64,
  parameter int FCS_BYTES  = 4,
  parameter int FIFO_DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       cmd_rx_we,
  input  logic       cmd_tx_we,
  input  logic [3:0] cmd_wdata,
  input  logic       rx_stat_rd,
  output logic [7:0] rx_stat,
  input  logic       tx_stat_rd,
  output logic [7:0] tx_stat,
  input  logic       tx_evt_valid,
  input  logic [3:0] tx_evt_code,
  input  logic       fifo_rd,
  output logic [7:0] fifo_data,
  output logic       fifo_eof,
  output logic       rx_ready,
  output logic       irq
);
  logic       in_frame_q, in_frame_d, accept_q, accept_d, accept_now;
  logic       keep_fcs, rx_old, take_en, frame_end, frame_fits, rx_upd;
  logic       res_good, res_crc_bad, res_short;
  logic       st_valid, st_last;
  logic [7:0] st_data;

  always_comb begin
    accept_now = in_frame_q ? accept_q : rx_old;
    take_en    = in_valid && accept_now;
    frame_end  = take_en && in_last;
    rx_upd     = frame_end && frame_fits;
    in_frame_d = in_valid ? !in_last : in_frame_q;
    accept_d   = (in_valid && !in_frame_q) ? rx_old : accept_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      accept_q   <= 1'b0;
    end else if (in_valid) begin
      in_frame_q <= in_frame_d;
      accept_q   <= accept_d;
    end
  end

  rxchk_classify #(.MIN_LEN(MIN_LEN)) i_classify (
    .clk(clk), .rst_n(rst_n),
    .byte_en(in_valid), .byte_last(in_last), .byte_in(in_data),
    .res_good(res_good), .res_crc_bad(res_crc_bad), .res_short(res_short)
  );

  rxchk_fcs_strip #(.FCS_BYTES(FCS_BYTES)) i_strip (
    .clk(clk), .rst_n(rst_n), .keep(keep_fcs),
    .byte_en(take_en), .byte_last(in_last), .byte_in(in_data),
    .out_valid(st_valid), .out_data(st_data), .out_last(st_last)
  );

  rxchk_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(st_valid), .wr_data(st_data), .wr_last(st_last),
    .frame_end(frame_end), .frame_fits(frame_fits),
    .rd_en(fifo_rd), .rd_data(fifo_data), .rd_last(fifo_eof), .ready(rx_ready)
  );

  rxchk_status i_status (
    .clk(clk), .rst_n(rst_n),
    .rx_cmd_we(cmd_rx_we), .tx_cmd_we(cmd_tx_we), .cmd_wdata(cmd_wdata),
    .rx_rd(rx_stat_rd), .tx_rd(tx_stat_rd),
    .rx_upd(rx_upd), .rx_code({res_short, res_crc_bad, res_good}),
    .tx_evt(tx_evt_valid), .tx_code(tx_evt_code),
    .rx_stat(rx_stat), .tx_stat(tx_stat),
    .keep_fcs(keep_fcs), .rx_old(rx_old), .irq(irq)
  );

  // R6
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_frame_q && !accept_q && !rx_stat_rd) |=> (rx_stat == $past(rx_stat)));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stat[7] && tx_stat[7]) |-> !irq);
endmodule

// File: tb/test_rx_frame_check.sv
module test_rx_frame_check;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic       cmd_rx_we = 1'b0, cmd_tx_we = 1'b0;
  logic [3:0] cmd_wdata = '0;
  logic       rx_stat_rd = 1'b0, tx_stat_rd = 1'b0;
  logic       tx_evt_valid = 1'b0;
  logic [3:0] tx_evt_code = '0;
  logic       fifo_rd = 1'b0;
  logic [7:0] rx_stat, tx_stat, fifo_data;
  logic       fifo_eof, rx_ready, irq;

  int total = 0;
  int bad = 0;
  bit drain_en = 1'b0;
  logic [8:0] exp_q [$];
  logic [7:0] fr [256];

  always #2.5 clk = ~clk;

  rx_frame_check i_rx_frame_check (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'd0, fr[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return c;
  endfunction

  // driver: builds a frame, pushes the bytes expected in the FIFO, streams it
  task automatic send_frame(input int n, input int seed, input bit corrupt,
                            input bit keep, input bit stored);
    logic [31:0] fcs;
    int tot = n + 4;
    int nst;
    for (int i = 0; i < n; i++) fr[i] = 8'(seed + i * 7);
    fcs = ~ref_crc(n);
    for (int i = 0; i < 4; i++) fr[n+i] = fcs[8*i +: 8];
    if (corrupt) fr[n] = fr[n] ^ 8'h10;
    nst = keep ? tot : n;
    if (stored)
      for (int i = 0; i < nst; i++) exp_q.push_back({(i == nst - 1), fr[i]});
    for (int i = 0; i < tot; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fr[i]; in_last = (i == tot - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic pulse_rx_rd();
    rx_stat_rd = 1'b1; @(negedge clk); rx_stat_rd = 1'b0;
  endtask

  task automatic wr_cmd(input bit tx, input logic [3:0] v);
    cmd_wdata = v; cmd_rx_we = !tx; cmd_tx_we = tx;
    @(negedge clk);
    cmd_rx_we = 1'b0; cmd_tx_we = 1'b0;
  endtask

  task automatic wait_drain(input string req);
    drain_en = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !rx_ready) break;
    end
    chk(exp_q.size() == 0 && !rx_ready, req, exp_q.size(), 0);
  endtask

  // monitor: compares the FIFO head with the scoreboard and pops it
  always @(negedge clk) begin
    if (drain_en && rx_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4/R5 unexpected byte", {fifo_eof, fifo_data}, 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({fifo_eof, fifo_data} == e, "R4/R5 fifo byte", {fifo_eof, fifo_data}, e);
      end
      fifo_rd = 1'b1;
    end else begin
      fifo_rd = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rx_stat == 8'h80, "R1 rx_stat", rx_stat, 8'h80);
    chk(tx_stat == 8'h80, "R1 tx_stat", tx_stat, 8'h80);
    chk(!irq && !rx_ready, "R1 irq/rx_ready", {irq, rx_ready}, 0);

    wr_cmd(1'b0, 4'h7);
    wr_cmd(1'b1, 4'hF);

    // R3 good frame, R4 strip
    send_frame(66, 3, 1'b0, 1'b0, 1'b1);
    chk(rx_stat == 8'h01, "R3 good", rx_stat, 8'h01);
    chk(irq, "R8 rx irq", irq, 1);
    chk(rx_ready, "R5 ready after frame", rx_ready, 1);
    wait_drain("R5 drained R4 strip");

    pulse_rx_rd();
    chk(rx_stat == 8'h81, "R7 read sets old", rx_stat, 8'h81);
    chk(!irq, "R7 irq cleared", irq, 0);

    // R3 crc error, R4 keep
    wr_cmd(1'b0, 4'hF);
    send_frame(66, 40, 1'b1, 1'b1, 1'b1);
    chk(rx_stat == 8'h02, "R3 crc error", rx_stat, 8'h02);
    wait_drain("R4 keep drained");

    // R6 drop while unread
    send_frame(66, 90, 1'b0, 1'b1, 1'b0);
    chk(rx_stat == 8'h02, "R6 status kept", rx_stat, 8'h02);
    chk(!rx_ready, "R6 nothing stored", rx_ready, 0);
    wait_drain("R6 fifo empty");

    // R2 short frame
    pulse_rx_rd();
    wr_cmd(1'b0, 4'h7);
    send_frame(16, 5, 1'b0, 1'b0, 1'b1);
    chk(rx_stat == 8'h04, "R2 short", rx_stat, 8'h04);
    chk(irq, "R8 short masked in", irq, 1);
    wr_cmd(1'b0, 4'h3);
    chk(!irq, "R8 short masked out", irq, 0);
    wait_drain("R2 short drained");

    // R9 transmit event
    pulse_rx_rd();
    tx_evt_code = 4'h5; tx_evt_valid = 1'b1;
    @(negedge clk);
    tx_evt_valid = 1'b0;
    chk(tx_stat == 8'h05, "R9 tx status", tx_stat, 8'h05);
    chk(irq, "R8 tx irq", irq, 1);
    tx_stat_rd = 1'b1; @(negedge clk); tx_stat_rd = 1'b0;
    chk(tx_stat == 8'h85, "R7 tx read", tx_stat, 8'h85);
    chk(!irq, "R7 tx irq cleared", irq, 0);

    // R10 overflow
    drain_en = 1'b0;
    wr_cmd(1'b0, 4'hB);
    send_frame(96, 11, 1'b0, 1'b1, 1'b1);
    chk(rx_stat == 8'h01, "R10 first frame good", rx_stat, 8'h01);
    pulse_rx_rd();
    send_frame(96, 60, 1'b0, 1'b1, 1'b0);
    chk(rx_stat == 8'h81, "R10 overflow status kept", rx_stat, 8'h81);
    wait_drain("R10 only first frame");
    send_frame(30, 77, 1'b0, 1'b1, 1'b1);
    chk(rx_stat == 8'h04, "R10 recovery short", rx_stat, 8'h04);
    wait_drain("R10 recovery drained");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule